// File: doc/BRIEF.md
# Two-Class Priority Bus Arbiter

This block picks the device that becomes the next bus master. It serves two classes of requester. A single direct-memory request line is checked on every bus-cycle strobe and wins over the processor. Four interrupt-level request lines are checked only when the processor signals the end of an instruction. Those levels are compared against the current processor priority and are held off after a trap. The arbiter raises one grant and waits for the selected device to acknowledge. It then tracks the handover: the current master releases bus-busy, and the new master drops its acknowledge. Only after that does the arbiter select again. The arbiter only selects a master. It moves no data and does not itself hand the bus over.

All request, acknowledge and bus-busy inputs are asynchronous to the arbiter clock. Each passes through a two-flop synchronizer before the state machine reads it. The processor-side strobes, the trap flag and the priority value are synchronous. The state machine has five states:
- `ARB_IDLE`: waiting for a strobe.
- `ARB_GNT_NPR`: the direct-memory grant is raised.
- `ARB_GNT_BR`: one level grant is raised.
- `ARB_SELECTED`: acknowledged, waiting for bus-busy to be seen low.
- `ARB_TAKEOVER`: waiting for the acknowledge to drop.

The transitions are:
- idle to direct-memory grant, on a bus-cycle strobe with the request present.
- idle to level grant, on an eligible instruction end.
- either grant to selected, on acknowledge.
- either grant to idle, on timeout.
- selected to takeover, when bus-busy is low.
- takeover to idle, when the acknowledge is low.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, `npg` and every bit of `bg` are low.
- R2: Every request, `sack` and `bbsy` input is sampled through a two-flop synchronizer. A request raised only one clock edge before the strobe edge is not seen. The strobe edge must be at least the third edge after the request rises.
- R3: In `ARB_IDLE`, with the synchronized acknowledge low, a `cycle_strobe` pulse while the synchronized `npr_req` is high raises `npg` in the next cycle.
- R4: When `cycle_strobe` and `instr_end` fall in the same cycle with both classes pending, the direct-memory request wins: `npg` rises and `bg` stays zero.
- R5: Level requests are evaluated only on `instr_end`. A `cycle_strobe` alone never raises `bg`.
- R6: Bit i of `br_req` is priority level 4+i, and bit i of `bg` is its grant. On an eligible `instr_end`, only the highest pending level is granted, and only if it is strictly greater than `cpu_prio`.
- R7: An `instr_end` with `trap` high grants no level. The next `instr_end`, which ends the trap sequence, grants none either. The one after that may grant again.
- R8: A grant stays high until the synchronized `sack` is seen. It drops in the cycle after that, which is three clock edges after `sack` rises at the pin.
- R9: After an acknowledge, no new grant is raised until the synchronized `bbsy` has been seen low and the synchronized `sack` has then dropped.
- R10: A grant that gets no acknowledge is withdrawn after exactly TIMEOUT cycles high. The arbiter is then idle and can grant again on the next strobe.
- R11: At most one grant output is high in any cycle.
- R12: Strobes that arrive while a grant or a handover is in progress have no effect on the grant outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low reset |
| npr_req | input | 1 | Direct-memory request, asynchronous |
| br_req | input | NLVL | Level requests, bit i = level BASE_LVL+i, asynchronous |
| cpu_prio | input | PW | Current processor priority |
| cycle_strobe | input | 1 | One-cycle pulse per bus cycle |
| instr_end | input | 1 | One-cycle pulse at end of instruction |
| trap | input | 1 | Qualifies `instr_end`: the instruction trapped |
| sack | input | 1 | Selection acknowledge from the chosen device |
| bbsy | input | 1 | Bus busy, held by the current master |
| npg | output | 1 | Direct-memory grant |
| bg | output | NLVL | Level grants, one-hot or zero |

## Verification
The two evaluation paths can fire in the same cycle. A bus-cycle strobe and an instruction-end strobe can both arrive with a direct-memory request and a granted-priority level pending at once. The bench provokes this with a directed pulse of both strobes. Its random loop also draws that combination often. The bench model decides by precedence that only `npg` may rise, and `bg` must stay zero. A second collision, an instruction end that arrives during an active grant, is judged by checking that the grant outputs do not change.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_GNT_NPR,
        ARB_GNT_BR,
        ARB_SELECTED,
        ARB_TAKEOVER
    } arb_state_t;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/arb_br_select.sv
module arb_br_select #(
    parameter int NLVL     = 4,
    parameter int PW       = 3,
    parameter int BASE_LVL = 4
) (
    input  logic [NLVL-1:0] req,
    input  logic [PW-1:0]   prio,
    output logic [NLVL-1:0] win,
    output logic            win_ok
);
    int top_lvl;
    logic any;

    // later (higher) bits overwrite lower ones: highest level wins
    always_comb begin
        win     = '0;
        top_lvl = 0;
        any     = 1'b0;
        for (int i = 0; i < NLVL; i++) begin
            if (req[i]) begin
                win     = '0;
                win[i]  = 1'b1;
                top_lvl = BASE_LVL + i;
                any     = 1'b1;
            end
        end
        win_ok = any && (top_lvl > int'(prio));
    end
endmodule

// File: rtl/arb_trap_gate.sv
module arb_trap_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_end,
    input  logic trap,
    output logic eligible
);
    logic blk;

    // one further instruction end (the trap sequence) stays blocked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blk <= 1'b0;
        else if (instr_end)
            blk <= trap;
    end

    assign eligible = instr_end && !trap && !blk;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_arb_pkg::*;
#(
    parameter int NLVL     = 4,
    parameter int PW       = 3,
    parameter int BASE_LVL = 4,
    parameter int TIMEOUT  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            npr_req,
    input  logic [NLVL-1:0] br_req,
    input  logic [PW-1:0]   cpu_prio,
    input  logic            cycle_strobe,
    input  logic            instr_end,
    input  logic            trap,
    input  logic            sack,
    input  logic            bbsy,
    output logic            npg,
    output logic [NLVL-1:0] bg
);
    localparam int SW = NLVL + 3;
    localparam int CW = $clog2(TIMEOUT + 1);

    arb_state_t      state, state_nx;
    logic [SW-1:0]   sync_q;
    logic            npr_s, sack_s, bbsy_s;
    logic [NLVL-1:0] br_s;
    logic [NLVL-1:0] win;
    logic            win_ok, eligible;
    logic [NLVL-1:0] bg_q;
    logic [CW-1:0]   cnt;
    logic            in_grant, timeout_hit, br_take;

    arb_sync #(.W(SW)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({bbsy, sack, npr_req, br_req}),
        .q    (sync_q)
    );
    assign {bbsy_s, sack_s, npr_s, br_s} = sync_q;

    arb_br_select #(.NLVL(NLVL), .PW(PW), .BASE_LVL(BASE_LVL)) u_sel (
        .req   (br_s),
        .prio  (cpu_prio),
        .win   (win),
        .win_ok(win_ok)
    );

    arb_trap_gate u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_end(instr_end),
        .trap     (trap),
        .eligible (eligible)
    );

    assign in_grant    = (state == ARB_GNT_NPR) || (state == ARB_GNT_BR);
    assign timeout_hit = (cnt == CW'(TIMEOUT - 1));
    assign br_take     = eligible && win_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ARB_IDLE;
        else
            state <= state_nx;
    end

    // grant age counter and latched level grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bg_q <= '0;
        end else begin
            if (in_grant && !timeout_hit)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
            if (state == ARB_IDLE && state_nx == ARB_GNT_BR)
                bg_q <= win;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_IDLE: begin
                if (!sack_s) begin
                    if (cycle_strobe && npr_s)
                        state_nx = ARB_GNT_NPR;
                    else if (br_take)
                        state_nx = ARB_GNT_BR;
                end
            end
            ARB_GNT_NPR, ARB_GNT_BR: begin
                if (sack_s)
                    state_nx = ARB_SELECTED;
                else if (timeout_hit)
                    state_nx = ARB_IDLE;
            end
            ARB_SELECTED: begin
                if (!bbsy_s)
                    state_nx = ARB_TAKEOVER;
            end
            ARB_TAKEOVER: begin
                if (!sack_s)
                    state_nx = ARB_IDLE;
            end
            default: state_nx = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        npg = 1'b0;
        bg  = '0;
        unique case (state)
            ARB_GNT_NPR: npg = 1'b1;
            ARB_GNT_BR:  bg  = bg_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int NLVL     = 4,
    parameter int PW       = 3,
    parameter int BASE_LVL = 4,
    parameter int TIMEOUT  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            npg,
    input logic [NLVL-1:0] bg,
    input logic [PW-1:0]   cpu_prio,
    input logic            cycle_strobe,
    input logic            instr_end,
    input logic            trap,
    input logic            npr_s,
    input logic            sack_s,
    input logic            idle
);
    localparam int RW = $clog2(TIMEOUT + 2);

    logic          any_g;
    logic [RW-1:0] run;

    assign any_g = npg || (|bg);

    function automatic int lvl_of(logic [NLVL-1:0] g);
        int l = 0;
        for (int i = 0; i < NLVL; i++)
            if (g[i]) l = BASE_LVL + i;
        return l;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run <= '0;
        else if (any_g)
            run <= run + 1'b1;
        else
            run <= '0;
    end

    a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({npg, bg}));

    a_r3_npr_granted: assert property (@(posedge clk) disable iff (!rst_n)
        idle && cycle_strobe && npr_s && !sack_s |=> npg);

    a_r4_npr_over_br: assert property (@(posedge clk) disable iff (!rst_n)
        idle && cycle_strobe && instr_end && npr_s && !sack_s |=> bg == '0);

    a_r6_above_prio: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|bg) |-> lvl_of(bg) > int'($past(cpu_prio)));

    a_r7_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        idle && instr_end && trap |=> bg == '0);

    a_r8_drop_on_sack: assert property (@(posedge clk) disable iff (!rst_n)
        any_g && sack_s |=> !any_g);

    a_r9_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        sack_s |=> !$rose(any_g));

    a_r10_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        any_g |-> run < RW'(TIMEOUT));
endmodule

bind bus_arbiter bus_arbiter_chk #(
    .NLVL(NLVL), .PW(PW), .BASE_LVL(BASE_LVL), .TIMEOUT(TIMEOUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .npg         (npg),
    .bg          (bg),
    .cpu_prio    (cpu_prio),
    .cycle_strobe(cycle_strobe),
    .instr_end   (instr_end),
    .trap        (trap),
    .npr_s       (npr_s),
    .sack_s      (sack_s),
    .idle        (state == bus_arb_pkg::ARB_IDLE)
);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
    localparam int NLVL = 4;
    localparam int TO   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            npr_req = 1'b0;
    logic [NLVL-1:0] br_req = '0;
    logic [2:0]      cpu_prio = '0;
    logic            cycle_strobe = 1'b0;
    logic            instr_end = 1'b0;
    logic            trap = 1'b0;
    logic            sack = 1'b0;
    logic            bbsy = 1'b0;
    logic            npg;
    logic [NLVL-1:0] bg;

    int n_chk = 0;
    int n_fail = 0;
    logic blk_m = 1'b0;
    bit done = 1'b0;

    bus_arbiter #(.TIMEOUT(TO)) i_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .npr_req(npr_req), .br_req(br_req),
        .cpu_prio(cpu_prio), .cycle_strobe(cycle_strobe),
        .instr_end(instr_end), .trap(trap), .sack(sack), .bbsy(bbsy),
        .npg(npg), .bg(bg)
    );

    always #10 clk = ~clk;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [4:0] exp);
        n_chk++;
        if ({npg, bg} !== exp) begin
            n_fail++;
            $display("FAIL %s: {npg,bg} actual %b expected %b at %0t",
                     req, {npg, bg}, exp, $time);
        end
    endtask

    function automatic logic [4:0] model(logic np, logic [3:0] br, logic [2:0] pr,
                                         logic cyc, logic ie, logic tr, logic blk);
        logic [3:0] w = '0;
        int lvl = 0;
        if (cyc && np) return 5'b10000;
        if (!ie || tr || blk) return 5'b0;
        for (int i = 0; i < 4; i++)
            if (br[i]) begin w = '0; w[i] = 1'b1; lvl = 4 + i; end
        if (br != 0 && lvl > int'(pr)) return {1'b0, w};
        return 5'b0;
    endfunction

    // one-cycle strobe pulse; called at a negedge, returns at the next
    task automatic pulse(logic cyc, logic ie, logic tr);
        cycle_strobe = cyc; instr_end = ie; trap = tr;
        @(negedge clk);
        cycle_strobe = 1'b0; instr_end = 1'b0; trap = 1'b0;
        if (ie) blk_m = tr;
    endtask

    task automatic release_grant(string req);
        sack = 1'b1;
        tick(2);
        n_chk++;
        if (!(npg || |bg)) begin
            n_fail++;
            $display("FAIL %s: grant dropped early, actual 0 expected 1", req);
        end
        tick(1);
        check(req, 5'b0);
        tick(2);
        sack = 1'b0;
        tick(4);
    endtask

    initial begin
        tick(200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [4:0] e;
        void'($urandom(32'd20250611));
        tick(3);
        check("R1 reset", 5'b0);
        rst_n = 1'b1;
        tick(2);
        check("R1 after reset", 5'b0);

        // R2: request only one edge old at the strobe edge is not seen
        npr_req = 1'b1;
        @(negedge clk);
        pulse(1'b1, 1'b0, 1'b0);
        check("R2 sync latency", 5'b0);
        tick(2);
        pulse(1'b1, 1'b0, 1'b0);
        check("R3 npr grant", 5'b10000);
        // R12: instruction end during a grant changes nothing
        br_req = 4'b1000; cpu_prio = 3'd0;
        tick(3);
        pulse(1'b0, 1'b1, 1'b0);
        check("R12 strobe ignored in grant", 5'b10000);
        release_grant("R8 sack withdraw");

        // R4: both strobes together
        pulse(1'b1, 1'b1, 1'b0);
        check("R4 npr precedence", 5'b10000);
        release_grant("R4 release");

        // R5: bus-cycle strobe alone never grants a level
        npr_req = 1'b0;
        tick(3);
        pulse(1'b1, 1'b0, 1'b0);
        check("R5 no br on cycle strobe", 5'b0);

        // R6: highest level over priority
        br_req = 4'b1010; cpu_prio = 3'd4; tick(3);
        pulse(1'b0, 1'b1, 1'b0);
        check("R6 level 7 wins", 5'b01000);
        release_grant("R6 release");
        cpu_prio = 3'd7;
        pulse(1'b0, 1'b1, 1'b0);
        check("R6 prio 7 masks", 5'b0);
        br_req = 4'b0011; cpu_prio = 3'd4; tick(3);
        pulse(1'b0, 1'b1, 1'b0);
        check("R6 level 5 over 4", 5'b00010);
        release_grant("R6 release2");
        cpu_prio = 3'd5;
        pulse(1'b0, 1'b1, 1'b0);
        check("R6 equal prio masks", 5'b0);

        // R7: trap blocks two instruction ends
        br_req = 4'b0001; cpu_prio = 3'd0; tick(3);
        pulse(1'b0, 1'b1, 1'b1);
        check("R7 trap instr", 5'b0);
        pulse(1'b0, 1'b1, 1'b0);
        check("R7 trap sequence end", 5'b0);
        pulse(1'b0, 1'b1, 1'b0);
        check("R7 grant resumes", 5'b00001);
        release_grant("R7 release");

        // R10: timeout
        br_req = '0; npr_req = 1'b1; tick(3);
        pulse(1'b1, 1'b0, 1'b0);
        check("R10 grant up", 5'b10000);
        tick(TO - 1);
        check("R10 held until limit", 5'b10000);
        tick(1);
        check("R10 withdrawn", 5'b0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R10 regrant", 5'b10000);

        // R9: handover waits for bus-busy low, then sack low
        bbsy = 1'b1;
        tick(3);
        sack = 1'b1;
        tick(3);
        check("R9 withdraw", 5'b0);
        sack = 1'b0;
        tick(5);
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 held while busy", 5'b0);
        bbsy = 1'b0;
        tick(5);
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 regrant after handover", 5'b10000);
        release_grant("R9 release");

        // constrained random
        for (int it = 0; it < 150; it++) begin
            logic c, ie, tr;
            int k;
            npr_req  = ($urandom % 3) == 0;
            br_req   = 4'($urandom);
            cpu_prio = 3'($urandom);
            k  = $urandom % 4;
            c  = (k == 0) || (k == 2);
            ie = (k == 1) || (k == 2);
            tr = ($urandom % 4) == 0;
            tick(3);
            e = model(npr_req, br_req, cpu_prio, c, ie, tr, blk_m);
            pulse(c, ie, tr);
            check(e[4] ? "R3 R4 random" : "R6 R7 R11 random", e);
            if (e != 0) release_grant("R8 random release");
            else tick(1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule